// File: doc/BRIEF.md
# Two-Stage Supply Startup and Fault Supervisor

This block decides when the boost front end and the resonant flyback stage of a two-stage supply may switch. Its inputs are comparator flags that have already been brought into its clock domain: three supply-rail levels (turn-on, run floor and shutdown floor), a rail over-voltage flag, two line-level flags, and flags for the boost feedback, open loop, sampled output over-voltage and two temperature-pin levels. Two flyback feedback flags set the light-load boost cut-off. From these it drives the run enables for both stages, the enable for the high-voltage start-up source, and a request to pull the boost error amplifier low. It also reports its state and the cause of the last trip.

Each fault has its own persistence counter, and every time limit is a parameter given in clock cycles. A counter starts over whenever its condition drops before the limit is reached. Some faults stop switching and let the rail fall to its shutdown floor before a fresh start (hiccup). Other faults hold every output off until the power-removal input asserts. The temperature pin has two levels, each with its own counter: a shallow dip is a slow over-temperature, and a deep dip is a fast external trip. The boost cut-off turns off slowly and turns back on quickly.

Top module: `psu_fault_supervisor`

## Requirements
- R1: After reset the state code is 0 (off), the start-up source is enabled, both run enables and the clamp request are low, and the fault cause is 0 (none).
- R2: From off, the block enters run (state code 1) on the first clock edge at which both the turn-on rail flag and the line start flag are high. In run the start-up source is disabled and the flyback run enable is high. Without the line start flag there is no start.
- R3: In run, loss of the run-floor rail flag moves the block to hiccup (state code 2). Hiccup never returns to run directly. It moves to off only once the shutdown-floor rail flag is low.
- R4: Rail over-voltage held for RAIL_OVP_CYC cycles moves the block to latched (state code 3) with cause 1. In latched, both run enables and the start-up source are low.
- R5: Latched is left only when power-removal asserts. That input moves the block to off and sets the cause to 0. Rail cycling while latched has no effect.
- R6: The brown-out flag held for BO_CYC cycles raises the clamp request. A high line start flag clears the request on the next edge.
- R7: In run, while the clamp request is up, the boost-feedback-low flag moves the block to hiccup with cause 6 on the next edge.
- R8: In run, open loop held for OLP_CYC cycles moves the block to hiccup with cause 3.
- R9: In run, sampled output over-voltage held for OUT_OVP_CYC cycles sets cause 2. The block goes to latched when the latch strap is 1 and to hiccup when it is 0.
- R10: In run, the deep temperature flag held for EXT_CYC cycles trips to hiccup with cause 5. The shallow flag alone needs OTP_CYC cycles and trips with cause 4.
- R11: The boost enable falls after the cut-off-low flag has been held for PFC_OFF_CYC cycles. It rises after the restore flag has been held for PFC_ON_CYC cycles. The boost run output is high only in run with the boost enable set, and the flyback keeps running meanwhile.
- R12: A persistence condition that drops before its limit causes no trip. The count starts again from zero.
- R13: When trips complete on the same edge, the cause is chosen in this order: rail over-voltage (1), output over-voltage (2), external (5), over-temperature (4), open loop (3), brown-out stop (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_removed | input | 1 | Power-removal event; clears latched state |
| rail_above_on | input | 1 | Supply rail above turn-on level |
| rail_above_run | input | 1 | Supply rail above switching floor |
| rail_above_off | input | 1 | Supply rail above shutdown floor |
| rail_ovp | input | 1 | Supply rail above over-voltage level |
| line_above_start | input | 1 | Line sense above start level |
| line_below_bo | input | 1 | Line sense below brown-out level |
| pfcfb_below_stop | input | 1 | Boost output feedback below stop level |
| fb_open_loop | input | 1 | Flyback feedback at open-loop level |
| out_ovp_sample | input | 1 | Sampled plateau above output over-voltage level |
| ovp_latch_strap | input | 1 | 1: output over-voltage latches; 0: hiccup |
| temp_below_otp | input | 1 | Temperature pin below shallow level |
| temp_below_ext | input | 1 | Temperature pin below deep level |
| fb_below_pfc_off | input | 1 | Flyback feedback below boost cut-off level |
| fb_above_pfc_on | input | 1 | Flyback feedback above boost restore level |
| pfc_run | output | 1 | Boost stage run enable |
| flyback_run | output | 1 | Flyback stage run enable |
| startup_src_en | output | 1 | High-voltage start-up source enable |
| ea_clamp | output | 1 | Boost error amplifier clamp request |
| sup_state | output | 2 | 0 off, 1 run, 2 hiccup, 3 latched |
| fault_cause | output | 3 | Last trip cause code |

## Verification
Each fault flag is first held one cycle short of its limit and then held past it. The short pulse shows that the counter starts over and does not accumulate. The output over-voltage trip runs under both strap values, which tells hiccup apart from latched. Rail cycling while latched shows that only power removal releases the block. The two temperature levels are driven separately so that the fast and slow limits produce different causes. Simultaneous output over-voltage and temperature trips show the cause priority. The boost cut-off is stepped in both directions to show the long and short limits.

// File: rtl/psu_sup_pkg.sv
package psu_sup_pkg;

   typedef enum logic [1:0] {
      SUP_OFF    = 2'd0,
      SUP_RUN    = 2'd1,
      SUP_HICCUP = 2'd2,
      SUP_LATCH  = 2'd3
   } sup_state_e;

   typedef enum logic [2:0] {
      CAUSE_NONE      = 3'd0,
      CAUSE_RAIL_OVP  = 3'd1,
      CAUSE_OUT_OVP   = 3'd2,
      CAUSE_OPEN_LOOP = 3'd3,
      CAUSE_OVERTEMP  = 3'd4,
      CAUSE_EXT_TRIP  = 3'd5,
      CAUSE_BROWNOUT  = 3'd6
   } cause_e;

   typedef struct packed {
      logic rail_ovp;
      logic out_ovp;
      logic ext;
      logic otp;
      logic olp;
      logic bo_stop;
   } trip_t;

   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/psu_debounce.sv
module psu_debounce #(
   parameter int unsigned LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic cond,
   output logic done
);
   localparam int unsigned W = psu_sup_pkg::cnt_width(LIMIT);
   localparam logic [W-1:0] TOP = W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("psu_debounce: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr || !en || !cond) begin
         cnt_q <= '0;
      end else if (cnt_q != TOP) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == TOP);

   // a dropped condition never leaves a completed count behind
   assert_restart_on_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cond |=> !done);

endmodule

// File: rtl/psu_pfc_gate.sv
module psu_pfc_gate #(
   parameter int unsigned OFF_CYC = 600000,
   parameter int unsigned ON_CYC  = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fb_below_off,
   input  logic fb_above_on,
   output logic pfc_en
);
   if (ON_CYC >= OFF_CYC) begin : g_bad_asym
      $error("psu_pfc_gate: restore limit must be shorter than cut-off limit");
   end

   logic off_done, on_done;

   psu_debounce #(.LIMIT(OFF_CYC)) u_off (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(pfc_en),
      .cond(fb_below_off), .done(off_done));

   psu_debounce #(.LIMIT(ON_CYC)) u_on (
      .clk(clk), .rst_n(rst_n), .clr(1'b0), .en(!pfc_en),
      .cond(fb_above_on), .done(on_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfc_en <= 1'b1;
      end else if (pfc_en && off_done) begin
         pfc_en <= 1'b0;
      end else if (!pfc_en && on_done) begin
         pfc_en <= 1'b1;
      end
   end

   assert_hold_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pfc_en && !fb_below_off |=> pfc_en);
   assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pfc_en && !fb_above_on |=> !pfc_en);

endmodule

// File: rtl/psu_uvlo_fsm.sv
module psu_uvlo_fsm
   import psu_sup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_removed,
   input  logic       rail_above_on,
   input  logic       rail_above_run,
   input  logic       rail_above_off,
   input  logic       line_above_start,
   input  logic       latch_strap,
   input  trip_t      trips,
   output sup_state_e state,
   output cause_e     cause
);
   sup_state_e st_d;
   cause_e     cause_d;

   always_comb begin
      st_d    = state;
      cause_d = cause;
      if (pwr_removed) begin
         st_d    = SUP_OFF;
         cause_d = CAUSE_NONE;
      end else if (trips.rail_ovp && state != SUP_LATCH) begin
         st_d    = SUP_LATCH;
         cause_d = CAUSE_RAIL_OVP;
      end else begin
         case (state)
            SUP_OFF: begin
               if (rail_above_on && line_above_start) st_d = SUP_RUN;
            end
            SUP_RUN: begin
               if (trips.out_ovp) begin
                  st_d    = latch_strap ? SUP_LATCH : SUP_HICCUP;
                  cause_d = CAUSE_OUT_OVP;
               end else if (trips.ext) begin
                  st_d    = SUP_HICCUP;
                  cause_d = CAUSE_EXT_TRIP;
               end else if (trips.otp) begin
                  st_d    = SUP_HICCUP;
                  cause_d = CAUSE_OVERTEMP;
               end else if (trips.olp) begin
                  st_d    = SUP_HICCUP;
                  cause_d = CAUSE_OPEN_LOOP;
               end else if (trips.bo_stop) begin
                  st_d    = SUP_HICCUP;
                  cause_d = CAUSE_BROWNOUT;
               end else if (!rail_above_run) begin
                  st_d    = SUP_HICCUP;
               end
            end
            SUP_HICCUP: begin
               if (!rail_above_off) st_d = SUP_OFF;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SUP_OFF;
         cause <= CAUSE_NONE;
      end else begin
         state <= st_d;
         cause <= cause_d;
      end
   end

   assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state == SUP_OFF && !(rail_above_on && line_above_start) |=> state != SUP_RUN);
   assert_hiccup_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state == SUP_HICCUP |=> state != SUP_RUN);
   assert_rail_ovp_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trips.rail_ovp && !pwr_removed |=> state == SUP_LATCH);
   assert_latch_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state == SUP_LATCH && !pwr_removed |=> state == SUP_LATCH);

endmodule

// File: rtl/psu_fault_supervisor.sv
module psu_fault_supervisor
   import psu_sup_pkg::*;
#(
   parameter int unsigned RAIL_OVP_CYC = 150,
   parameter int unsigned OUT_OVP_CYC  = 170,
   parameter int unsigned EXT_CYC      = 100,
   parameter int unsigned OTP_CYC      = 10000,
   parameter int unsigned OLP_CYC      = 55000,
   parameter int unsigned BO_CYC       = 110000,
   parameter int unsigned PFC_OFF_CYC  = 600000,
   parameter int unsigned PFC_ON_CYC   = 150
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_removed,
   input  logic       rail_above_on,
   input  logic       rail_above_run,
   input  logic       rail_above_off,
   input  logic       rail_ovp,
   input  logic       line_above_start,
   input  logic       line_below_bo,
   input  logic       pfcfb_below_stop,
   input  logic       fb_open_loop,
   input  logic       out_ovp_sample,
   input  logic       ovp_latch_strap,
   input  logic       temp_below_otp,
   input  logic       temp_below_ext,
   input  logic       fb_below_pfc_off,
   input  logic       fb_above_pfc_on,
   output logic       pfc_run,
   output logic       flyback_run,
   output logic       startup_src_en,
   output logic       ea_clamp,
   output logic [1:0] sup_state,
   output logic [2:0] fault_cause
);
   if (EXT_CYC >= OTP_CYC) begin : g_bad_temp
      $error("psu_fault_supervisor: deep temperature limit must be shorter");
   end

   sup_state_e state;
   cause_e     cause;
   trip_t      trips;
   logic       running, not_latched, bo_done, bo_active, pfc_en;

   assign running     = (state == SUP_RUN);
   assign not_latched = (state != SUP_LATCH);

   psu_debounce #(.LIMIT(RAIL_OVP_CYC)) u_rail_ovp (
      .clk(clk), .rst_n(rst_n), .clr(pwr_removed), .en(not_latched),
      .cond(rail_ovp), .done(trips.rail_ovp));
   psu_debounce #(.LIMIT(OUT_OVP_CYC)) u_out_ovp (
      .clk(clk), .rst_n(rst_n), .clr(pwr_removed), .en(running),
      .cond(out_ovp_sample), .done(trips.out_ovp));
   psu_debounce #(.LIMIT(EXT_CYC)) u_ext (
      .clk(clk), .rst_n(rst_n), .clr(pwr_removed), .en(running),
      .cond(temp_below_ext), .done(trips.ext));
   psu_debounce #(.LIMIT(OTP_CYC)) u_otp (
      .clk(clk), .rst_n(rst_n), .clr(pwr_removed), .en(running),
      .cond(temp_below_otp), .done(trips.otp));
   psu_debounce #(.LIMIT(OLP_CYC)) u_olp (
      .clk(clk), .rst_n(rst_n), .clr(pwr_removed), .en(running),
      .cond(fb_open_loop), .done(trips.olp));
   psu_debounce #(.LIMIT(BO_CYC)) u_bo (
      .clk(clk), .rst_n(rst_n), .clr(pwr_removed), .en(1'b1),
      .cond(line_below_bo), .done(bo_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bo_active <= 1'b0;
      end else if (pwr_removed || line_above_start) begin
         bo_active <= 1'b0;
      end else if (bo_done) begin
         bo_active <= 1'b1;
      end
   end

   assign trips.bo_stop = bo_active && pfcfb_below_stop;

   psu_pfc_gate #(.OFF_CYC(PFC_OFF_CYC), .ON_CYC(PFC_ON_CYC)) u_pfc_gate (
      .clk(clk), .rst_n(rst_n), .fb_below_off(fb_below_pfc_off),
      .fb_above_on(fb_above_pfc_on), .pfc_en(pfc_en));

   psu_uvlo_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .pwr_removed(pwr_removed),
      .rail_above_on(rail_above_on), .rail_above_run(rail_above_run),
      .rail_above_off(rail_above_off), .line_above_start(line_above_start),
      .latch_strap(ovp_latch_strap), .trips(trips), .state(state), .cause(cause));

   assign flyback_run    = running;
   assign pfc_run        = running && pfc_en;
   assign startup_src_en = (state == SUP_OFF);
   assign ea_clamp       = bo_active;
   assign sup_state      = state;
   assign fault_cause    = cause;

   assert_clamp_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      line_above_start |=> !ea_clamp);
   assert_bo_stop_hiccup_R7: assert property (@(posedge clk) disable iff (!rst_n)
      running && trips.bo_stop && !trips.rail_ovp && !trips.out_ovp && !trips.ext
      && !trips.otp && !trips.olp && !pwr_removed |=> sup_state == 2'd2 && fault_cause == 3'd6);

endmodule

// File: tb/psu_fault_supervisor_test.sv
module psu_fault_supervisor_test;
   localparam int CLK_PERIOD = 10;
   localparam int P_RAIL = 6, P_OUT = 6, P_EXT = 6, P_OTP = 20;
   localparam int P_OLP = 15, P_BO = 25, P_POFF = 30, P_PON = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pwr_removed = 0, rail_above_on = 0, rail_above_run = 0, rail_above_off = 0;
   logic rail_ovp = 0, line_above_start = 0, line_below_bo = 0, pfcfb_below_stop = 0;
   logic fb_open_loop = 0, out_ovp_sample = 0, ovp_latch_strap = 0;
   logic temp_below_otp = 0, temp_below_ext = 0, fb_below_pfc_off = 0, fb_above_pfc_on = 0;
   logic pfc_run, flyback_run, startup_src_en, ea_clamp;
   logic [1:0] sup_state;
   logic [2:0] fault_cause;

   int checks = 0, errors = 0;
   string cur_req = "R1";
   bit done_run = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   psu_fault_supervisor #(
      .RAIL_OVP_CYC(P_RAIL), .OUT_OVP_CYC(P_OUT), .EXT_CYC(P_EXT), .OTP_CYC(P_OTP),
      .OLP_CYC(P_OLP), .BO_CYC(P_BO), .PFC_OFF_CYC(P_POFF), .PFC_ON_CYC(P_PON)
   ) uut (.*);

   // behavioural reference model
   int m_st, m_cause, c_rail, c_out, c_ext, c_otp, c_olp, c_bo, c_poff, c_pon;
   bit m_bo, m_pfc;

   function automatic int bump(int c, int lim, bit clr, bit en, bit cond);
      if (clr || !en || !cond) return 0;
      return (c < lim) ? c + 1 : c;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cause = 0; m_bo = 0; m_pfc = 1;
         c_rail = 0; c_out = 0; c_ext = 0; c_otp = 0; c_olp = 0; c_bo = 0; c_poff = 0; c_pon = 0;
      end else begin
         bit t_rail, t_out, t_ext, t_otp, t_olp, t_bo, d_bo, d_off, d_on, run;
         int nst, nca;
         t_rail = (c_rail == P_RAIL); t_out = (c_out == P_OUT); t_ext = (c_ext == P_EXT);
         t_otp = (c_otp == P_OTP); t_olp = (c_olp == P_OLP); d_bo = (c_bo == P_BO);
         d_off = (c_poff == P_POFF); d_on = (c_pon == P_PON);
         t_bo = m_bo && pfcfb_below_stop;
         run = (m_st == 1);
         c_rail = bump(c_rail, P_RAIL, pwr_removed, m_st != 3, rail_ovp);
         c_out = bump(c_out, P_OUT, pwr_removed, run, out_ovp_sample);
         c_ext = bump(c_ext, P_EXT, pwr_removed, run, temp_below_ext);
         c_otp = bump(c_otp, P_OTP, pwr_removed, run, temp_below_otp);
         c_olp = bump(c_olp, P_OLP, pwr_removed, run, fb_open_loop);
         c_bo = bump(c_bo, P_BO, pwr_removed, 1, line_below_bo);
         c_poff = bump(c_poff, P_POFF, 0, m_pfc, fb_below_pfc_off);
         c_pon = bump(c_pon, P_PON, 0, !m_pfc, fb_above_pfc_on);
         if (m_pfc && d_off) m_pfc = 0; else if (!m_pfc && d_on) m_pfc = 1;
         nst = m_st; nca = m_cause;
         if (pwr_removed) begin nst = 0; nca = 0; end
         else if (t_rail && m_st != 3) begin nst = 3; nca = 1; end
         else if (m_st == 0) begin if (rail_above_on && line_above_start) nst = 1; end
         else if (m_st == 1) begin
            if (t_out) begin nst = ovp_latch_strap ? 3 : 2; nca = 2; end
            else if (t_ext) begin nst = 2; nca = 5; end
            else if (t_otp) begin nst = 2; nca = 4; end
            else if (t_olp) begin nst = 2; nca = 3; end
            else if (t_bo) begin nst = 2; nca = 6; end
            else if (!rail_above_run) nst = 2;
         end else if (m_st == 2) begin if (!rail_above_off) nst = 0; end
         if (pwr_removed || line_above_start) m_bo = 0; else if (d_bo) m_bo = 1;
         m_st = nst; m_cause = nca;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done_run) begin
         chk({cur_req, " model state"}, sup_state, m_st);
         chk({cur_req, " model cause"}, fault_cause, m_cause);
         chk({cur_req, " model flyback_run"}, flyback_run, m_st == 1);
         chk({cur_req, " model pfc_run"}, pfc_run, (m_st == 1) && m_pfc);
         chk({cur_req, " model startup_src_en"}, startup_src_en, m_st == 0);
         chk({cur_req, " model ea_clamp"}, ea_clamp, m_bo);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic recycle();
      rail_above_off = 0; rail_above_run = 0; rail_above_on = 0;
      cyc(2);
      rail_above_off = 1; rail_above_run = 1; rail_above_on = 1;
      cyc(2);
      rail_above_on = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cyc(3); rst_n = 1; cyc(1);
      cur_req = "R1";
      chk("R1 state", sup_state, 0); chk("R1 src", startup_src_en, 1);
      chk("R1 flyback", flyback_run, 0); chk("R1 pfc", pfc_run, 0);
      chk("R1 clamp", ea_clamp, 0); chk("R1 cause", fault_cause, 0);

      cur_req = "R2";
      rail_above_off = 1; rail_above_run = 1; rail_above_on = 1;
      cyc(4); chk("R2 no start without line", sup_state, 0);
      line_above_start = 1; cyc(1);
      chk("R2 state", sup_state, 1); chk("R2 src off", startup_src_en, 0);
      chk("R2 flyback", flyback_run, 1); chk("R2 pfc", pfc_run, 1);
      rail_above_on = 0; cyc(3); chk("R2 stays run", sup_state, 1);

      cur_req = "R12";
      fb_open_loop = 1; cyc(P_OLP - 1); fb_open_loop = 0; cyc(3);
      chk("R12 short open loop", sup_state, 1);
      cur_req = "R8";
      fb_open_loop = 1; cyc(P_OLP + 3);
      chk("R8 state", sup_state, 2); chk("R8 cause", fault_cause, 3);
      fb_open_loop = 0;
      cur_req = "R3";
      rail_above_on = 1; cyc(3); chk("R3 no direct restart", sup_state, 2);
      rail_above_on = 0; rail_above_off = 0; rail_above_run = 0; cyc(2);
      chk("R3 off below floor", sup_state, 0);
      rail_above_off = 1; rail_above_run = 1; rail_above_on = 1; cyc(2); rail_above_on = 0;
      chk("R3 restarted", sup_state, 1);
      rail_above_run = 0; cyc(2);
      chk("R3 run floor hiccup", sup_state, 2); chk("R3 cause kept", fault_cause, 3);
      recycle();

      cur_req = "R6";
      line_above_start = 0; line_below_bo = 1; cyc(P_BO + 3);
      chk("R6 clamp", ea_clamp, 1); chk("R6 still run", sup_state, 1);
      cur_req = "R7";
      pfcfb_below_stop = 1; cyc(2);
      chk("R7 state", sup_state, 2); chk("R7 cause", fault_cause, 6);
      pfcfb_below_stop = 0;
      rail_above_off = 0; rail_above_run = 0; cyc(2);
      rail_above_off = 1; rail_above_run = 1; rail_above_on = 1; cyc(4);
      chk("R6 no start in brown-out", sup_state, 0); chk("R6 clamp held", ea_clamp, 1);
      line_below_bo = 0; line_above_start = 1; cyc(2);
      chk("R6 clamp released", ea_clamp, 0); chk("R6 run", sup_state, 1);
      rail_above_on = 0;

      cur_req = "R10";
      temp_below_otp = 1; temp_below_ext = 1; cyc(P_EXT + 3);
      chk("R10 ext state", sup_state, 2); chk("R10 ext cause", fault_cause, 5);
      temp_below_otp = 0; temp_below_ext = 0; recycle();
      temp_below_otp = 1; cyc(P_EXT + 3); chk("R10 shallow slow", sup_state, 1);
      cyc(P_OTP); chk("R10 otp state", sup_state, 2); chk("R10 otp cause", fault_cause, 4);
      temp_below_otp = 0; recycle();

      cur_req = "R9";
      out_ovp_sample = 1; cyc(P_OUT + 3);
      chk("R9 hiccup", sup_state, 2); chk("R9 cause", fault_cause, 2);
      out_ovp_sample = 0; recycle();
      ovp_latch_strap = 1; out_ovp_sample = 1; cyc(P_OUT + 3);
      chk("R9 latched", sup_state, 3); chk("R9 src", startup_src_en, 0);
      chk("R9 flyback", flyback_run, 0); chk("R9 pfc", pfc_run, 0); chk("R9 cause2", fault_cause, 2);
      out_ovp_sample = 0;

      cur_req = "R5";
      rail_above_off = 0; rail_above_run = 0; cyc(3);
      rail_above_off = 1; rail_above_run = 1; rail_above_on = 1; cyc(3);
      chk("R5 rail cycle ignored", sup_state, 3);
      pwr_removed = 1; cyc(1); pwr_removed = 0;
      chk("R5 released", sup_state, 0); chk("R5 cause cleared", fault_cause, 0);
      cyc(1); chk("R5 restart", sup_state, 1);
      rail_above_on = 0; ovp_latch_strap = 0;

      cur_req = "R4";
      rail_ovp = 1; cyc(P_RAIL + 3);
      chk("R4 latched", sup_state, 3); chk("R4 cause", fault_cause, 1);
      chk("R4 src", startup_src_en, 0); chk("R4 flyback", flyback_run, 0);
      rail_ovp = 0; cyc(5); chk("R4 holds", sup_state, 3);
      pwr_removed = 1; rail_above_on = 1; cyc(1); pwr_removed = 0; cyc(1); rail_above_on = 0;
      chk("R4 back to run", sup_state, 1);

      cur_req = "R13";
      out_ovp_sample = 1; temp_below_otp = 1; temp_below_ext = 1; cyc(P_OUT + 3);
      chk("R13 state", sup_state, 2); chk("R13 priority cause", fault_cause, 2);
      out_ovp_sample = 0; temp_below_otp = 0; temp_below_ext = 0; recycle();

      cur_req = "R11";
      fb_below_pfc_off = 1; cyc(P_POFF - 1); fb_below_pfc_off = 0; cyc(2);
      chk("R12 short cut-off", pfc_run, 1);
      fb_below_pfc_off = 1; cyc(P_POFF + 3);
      chk("R11 pfc off", pfc_run, 0); chk("R11 flyback on", flyback_run, 1);
      fb_below_pfc_off = 0; fb_above_pfc_on = 1; cyc(P_PON - 1); fb_above_pfc_on = 0; cyc(2);
      chk("R12 short restore", pfc_run, 0);
      fb_above_pfc_on = 1; cyc(P_PON + 3);
      chk("R11 pfc back", pfc_run, 1);
      fb_above_pfc_on = 0; cyc(2);

      done_run = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule